// File: doc/BRIEF.md
# Reorder-Buffer-Tagged Reservation Station Pool

This block is the waiting room in front of one functional unit of a speculative out-of-order core. Each issued operation arrives with its operation code, the reorder-buffer slot that will hold its result, and two source operands. Each operand comes either as a value or as the tag of the reorder-buffer slot that will produce it. A value may come from the architectural register file or, speculatively, from an older reorder-buffer slot that has completed but not yet committed. The pool does not care which of the two it is.

Stations whose operands are still pending watch the common data bus (CDB). When a broadcast carries a tag they are waiting for, they take its value. Once both operands are present and the unit signals it can accept work, one ready station is handed to the unit together with its destination reorder-buffer tag, and that station becomes free. A flush, raised when a misprediction reaches the head of the reorder buffer, empties the whole pool at once.

Top module: `rtp_pool`

## Requirements
- R1: An issue is accepted only in a cycle where `iss_valid`, `rob_free` and `iss_ready` are all high. `iss_ready` is high exactly when at least one station is free. An issue offered at any other time leaves no trace in later dispatches.
- R2: A dispatched operation carries the operation code and destination reorder-buffer tag it was issued with.
- R3: An operand issued with its pending flag low holds the supplied value, and that value is dispatched unchanged.
- R4: A pending operand takes the CDB value on a cycle where `cdb_valid` is high and `cdb_tag` equals its tag. After that cycle the operand is present. Broadcasts with any other tag leave it pending.
- R5: When an operand is issued pending on the same cycle that the CDB broadcasts its tag, the broadcast value is captured at once. The operand is then present on the next cycle.
- R6: `disp_valid` is high only when `fu_ready` is high and some station holds both operands present. The dispatch outputs are combinational from station state in the same cycle.
- R7: When several stations are ready, the lowest-index one is dispatched. At most one dispatch happens per cycle, and the dispatched station is free from the next cycle.
- R8: While `flush` is high, `disp_valid` is low and any issue is ignored. After the flush edge every station is free.
- R9: After reset every station is free, `iss_ready` is high and `disp_valid` is low.
- R10: An accepted issue goes into the lowest-index free station.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard every waiting station |
| rob_free | input | 1 | A reorder-buffer slot is available for the issuing op |
| iss_valid | input | 1 | Issue request |
| iss_ready | output | 1 | At least one station is free |
| iss_op | input | OP_W | Operation code |
| iss_dst | input | TAG_W | Destination reorder-buffer tag |
| iss_a_pend | input | 1 | Operand A is waiting on `iss_a_tag` |
| iss_a_tag | input | TAG_W | Producer tag of operand A |
| iss_a_val | input | DATA_W | Value of operand A when not pending |
| iss_b_pend | input | 1 | Operand B is waiting on `iss_b_tag` |
| iss_b_tag | input | TAG_W | Producer tag of operand B |
| iss_b_val | input | DATA_W | Value of operand B when not pending |
| cdb_valid | input | 1 | CDB broadcast present |
| cdb_tag | input | TAG_W | Reorder-buffer tag of the broadcast result |
| cdb_val | input | DATA_W | Broadcast result value |
| fu_ready | input | 1 | Functional unit accepts an operation this cycle |
| disp_valid | output | 1 | An operation is dispatched this cycle |
| disp_op | output | OP_W | Dispatched operation code |
| disp_dst | output | TAG_W | Dispatched destination reorder-buffer tag |
| disp_a | output | DATA_W | Dispatched operand A |
| disp_b | output | DATA_W | Dispatched operand B |

## Verification
Two functions can meet in one cycle: a CDB broadcast and the issue of an operation that waits on that same tag. The bench raises both on one edge, with one operand matching the broadcast and the other not. It then confirms that only the matching operand is present and that the dispatched A value is the broadcast value. A second collision, a flush landing while `fu_ready` and `iss_valid` are high, is judged by `disp_valid` staying low that cycle and by no entry surfacing afterwards.

// File: rtl/rtp_pkg.sv
package rtp_pkg;
   typedef enum logic {
      PICK_LOW  = 1'b0,
      PICK_HIGH = 1'b1
   } pick_order_e;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/rtp_pick.sv
module rtp_pick
   import rtp_pkg::*;
#(
   parameter int unsigned N     = 4,
   parameter pick_order_e ORDER = PICK_LOW
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt,
   output logic         any
);
   generate
      if (N < 1) begin : g_bad_n
         $error("rtp_pick: N must be at least 1");
      end
   endgenerate

   assign any = |req;

   generate
      if (ORDER == PICK_LOW) begin : g_low
         always_comb begin
            logic found;
            found = 1'b0;
            gnt   = '0;
            for (int i = 0; i < int'(N); i++) begin
               if (!found && req[i]) begin
                  gnt[i] = 1'b1;
                  found  = 1'b1;
               end
            end
         end
      end else begin : g_high
         always_comb begin
            logic found;
            found = 1'b0;
            gnt   = '0;
            for (int i = int'(N) - 1; i >= 0; i--) begin
               if (!found && req[i]) begin
                  gnt[i] = 1'b1;
                  found  = 1'b1;
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/rtp_operand.sv
module rtp_operand #(
   parameter int unsigned TAG_W  = 3,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              live,
   input  logic              in_pend,
   input  logic [TAG_W-1:0]  in_tag,
   input  logic [DATA_W-1:0] in_val,
   input  logic              cdb_valid,
   input  logic [TAG_W-1:0]  cdb_tag,
   input  logic [DATA_W-1:0] cdb_val,
   output logic              pend,
   output logic [DATA_W-1:0] val
);
   logic [TAG_W-1:0] tag_q;
   logic             fwd_hit;
   logic             snoop_hit;

   assign fwd_hit   = in_pend && cdb_valid && (cdb_tag == in_tag);
   assign snoop_hit = live && pend && cdb_valid && (cdb_tag == tag_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend  <= 1'b0;
         tag_q <= '0;
         val   <= '0;
      end else if (load) begin
         pend  <= in_pend && !fwd_hit;
         tag_q <= in_tag;
         val   <= fwd_hit ? cdb_val : in_val;
      end else if (snoop_hit) begin
         pend <= 1'b0;
         val  <= cdb_val;
      end
   end
endmodule

// File: rtl/rtp_station.sv
module rtp_station #(
   parameter int unsigned OP_W   = 4,
   parameter int unsigned TAG_W  = 3,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              alloc,
   input  logic              take,
   input  logic [OP_W-1:0]   in_op,
   input  logic [TAG_W-1:0]  in_dst,
   input  logic [1:0]        in_pend,
   input  logic [TAG_W-1:0]  in_tag [2],
   input  logic [DATA_W-1:0] in_val [2],
   input  logic              cdb_valid,
   input  logic [TAG_W-1:0]  cdb_tag,
   input  logic [DATA_W-1:0] cdb_val,
   output logic              valid,
   output logic              ready,
   output logic [OP_W-1:0]   op,
   output logic [TAG_W-1:0]  dst,
   output logic [DATA_W-1:0] val [2]
);
   logic [1:0] pend;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid <= 1'b0;
         op    <= '0;
         dst   <= '0;
      end else if (flush) begin
         valid <= 1'b0;
      end else if (alloc) begin
         valid <= 1'b1;
         op    <= in_op;
         dst   <= in_dst;
      end else if (take) begin
         valid <= 1'b0;
      end
   end

   generate
      for (genvar k = 0; k < 2; k++) begin : g_opnd
         rtp_operand #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_opnd (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (alloc && !flush),
            .live     (valid),
            .in_pend  (in_pend[k]),
            .in_tag   (in_tag[k]),
            .in_val   (in_val[k]),
            .cdb_valid(cdb_valid),
            .cdb_tag  (cdb_tag),
            .cdb_val  (cdb_val),
            .pend     (pend[k]),
            .val      (val[k])
         );
      end
   endgenerate

   assign ready = valid && (pend == 2'b00);
endmodule

// File: rtl/rtp_pool.sv
module rtp_pool
   import rtp_pkg::*;
#(
   parameter int unsigned N_STN  = 4,
   parameter int unsigned OP_W   = 4,
   parameter int unsigned TAG_W  = 3,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              rob_free,
   input  logic              iss_valid,
   output logic              iss_ready,
   input  logic [OP_W-1:0]   iss_op,
   input  logic [TAG_W-1:0]  iss_dst,
   input  logic              iss_a_pend,
   input  logic [TAG_W-1:0]  iss_a_tag,
   input  logic [DATA_W-1:0] iss_a_val,
   input  logic              iss_b_pend,
   input  logic [TAG_W-1:0]  iss_b_tag,
   input  logic [DATA_W-1:0] iss_b_val,
   input  logic              cdb_valid,
   input  logic [TAG_W-1:0]  cdb_tag,
   input  logic [DATA_W-1:0] cdb_val,
   input  logic              fu_ready,
   output logic              disp_valid,
   output logic [OP_W-1:0]   disp_op,
   output logic [TAG_W-1:0]  disp_dst,
   output logic [DATA_W-1:0] disp_a,
   output logic [DATA_W-1:0] disp_b
);
   localparam int unsigned IDX_W = idx_width(N_STN);

   generate
      if (N_STN < 1) begin : g_bad_depth
         $error("rtp_pool: N_STN must be at least 1");
      end
      if (TAG_W < 1 || DATA_W < 1 || OP_W < 1) begin : g_bad_width
         $error("rtp_pool: widths must be positive");
      end
      if (IDX_W > 16) begin : g_bad_idx
         $error("rtp_pool: pool too deep");
      end
   endgenerate

   logic [N_STN-1:0]  stn_valid;
   logic [N_STN-1:0]  stn_ready;
   logic [N_STN-1:0]  free_gnt;
   logic [N_STN-1:0]  rdy_gnt;
   logic [N_STN-1:0]  alloc_vec;
   logic [N_STN-1:0]  take_vec;
   logic              any_free;
   logic              any_rdy;
   logic              iss_acc;
   logic [OP_W-1:0]   stn_op  [N_STN];
   logic [TAG_W-1:0]  stn_dst [N_STN];
   logic [DATA_W-1:0] stn_val [N_STN][2];
   logic [TAG_W-1:0]  iss_tag [2];
   logic [DATA_W-1:0] iss_val [2];

   assign iss_tag[0] = iss_a_tag;
   assign iss_tag[1] = iss_b_tag;
   assign iss_val[0] = iss_a_val;
   assign iss_val[1] = iss_b_val;

   rtp_pick #(.N(N_STN), .ORDER(PICK_LOW)) u_free_pick (
      .req(~stn_valid),
      .gnt(free_gnt),
      .any(any_free)
   );

   rtp_pick #(.N(N_STN), .ORDER(PICK_LOW)) u_rdy_pick (
      .req(stn_ready),
      .gnt(rdy_gnt),
      .any(any_rdy)
   );

   assign iss_ready  = any_free;
   assign iss_acc    = iss_valid && rob_free && any_free && !flush;
   assign alloc_vec  = iss_acc ? free_gnt : '0;
   assign disp_valid = any_rdy && fu_ready && !flush;
   assign take_vec   = disp_valid ? rdy_gnt : '0;

   generate
      for (genvar s = 0; s < N_STN; s++) begin : g_stn
         rtp_station #(.OP_W(OP_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_stn (
            .clk      (clk),
            .rst_n    (rst_n),
            .flush    (flush),
            .alloc    (alloc_vec[s]),
            .take     (take_vec[s]),
            .in_op    (iss_op),
            .in_dst   (iss_dst),
            .in_pend  ({iss_b_pend, iss_a_pend}),
            .in_tag   (iss_tag),
            .in_val   (iss_val),
            .cdb_valid(cdb_valid),
            .cdb_tag  (cdb_tag),
            .cdb_val  (cdb_val),
            .valid    (stn_valid[s]),
            .ready    (stn_ready[s]),
            .op       (stn_op[s]),
            .dst      (stn_dst[s]),
            .val      (stn_val[s])
         );
      end
   endgenerate

   always_comb begin
      disp_op  = '0;
      disp_dst = '0;
      disp_a   = '0;
      disp_b   = '0;
      for (int s = 0; s < int'(N_STN); s++) begin
         if (rdy_gnt[s]) begin
            disp_op  = disp_op  | stn_op[s];
            disp_dst = disp_dst | stn_dst[s];
            disp_a   = disp_a   | stn_val[s][0];
            disp_b   = disp_b   | stn_val[s][1];
         end
      end
   end
endmodule

// File: rtl/rtp_pool_chk.sv
module rtp_pool_chk #(
   parameter int unsigned N = 4
) (
   input logic         clk,
   input logic         rst_n,
   input logic         flush,
   input logic         rob_free,
   input logic         iss_valid,
   input logic         fu_ready,
   input logic         disp_valid,
   input logic [N-1:0] stn_valid
);
   p_disp_needs_unit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      disp_valid |-> fu_ready);

   p_flush_no_disp_r8: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> !disp_valid);

   p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (stn_valid == '0));

   p_rob_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!rob_free && !flush) |=> ($countones(stn_valid) <= $past($countones(stn_valid))));

   p_disp_frees_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_valid && !iss_valid) |=> ($countones(stn_valid) + 1 == $past($countones(stn_valid))));
endmodule

bind rtp_pool rtp_pool_chk #(.N(N_STN)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .flush     (flush),
   .rob_free  (rob_free),
   .iss_valid (iss_valid),
   .fu_ready  (fu_ready),
   .disp_valid(disp_valid),
   .stn_valid (stn_valid)
);

// File: tb/tb_rtp_pool.sv
module tb_rtp_pool;
   localparam int N_STN = 4, OP_W = 4, TAG_W = 3, DATA_W = 16;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              flush, rob_free, iss_valid, iss_ready;
   logic [OP_W-1:0]   iss_op;
   logic [TAG_W-1:0]  iss_dst, iss_a_tag, iss_b_tag, cdb_tag, disp_dst;
   logic              iss_a_pend, iss_b_pend, cdb_valid, fu_ready, disp_valid;
   logic [DATA_W-1:0] iss_a_val, iss_b_val, cdb_val, disp_a, disp_b;
   logic [OP_W-1:0]   disp_op;

   int checks = 0, failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   rtp_pool #(.N_STN(N_STN), .OP_W(OP_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) dut (
      .clk(clk), .rst_n(rst_n), .flush(flush), .rob_free(rob_free),
      .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_op(iss_op), .iss_dst(iss_dst),
      .iss_a_pend(iss_a_pend), .iss_a_tag(iss_a_tag), .iss_a_val(iss_a_val),
      .iss_b_pend(iss_b_pend), .iss_b_tag(iss_b_tag), .iss_b_val(iss_b_val),
      .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_val(cdb_val), .fu_ready(fu_ready),
      .disp_valid(disp_valid), .disp_op(disp_op), .disp_dst(disp_dst),
      .disp_a(disp_a), .disp_b(disp_b)
   );

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic expect_disp(input string req, input logic [TAG_W-1:0] dst,
                              input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b);
      #1;
      chk(req, "disp_valid", 32'(disp_valid), 32'd1);
      chk(req, "disp_dst", 32'(disp_dst), 32'(dst));
      chk(req, "disp_a", 32'(disp_a), 32'(a));
      chk(req, "disp_b", 32'(disp_b), 32'(b));
   endtask

   task automatic issue(input logic [OP_W-1:0] op, input logic [TAG_W-1:0] dst,
                        input logic ap, input logic [TAG_W-1:0] at, input logic [DATA_W-1:0] av,
                        input logic bp, input logic [TAG_W-1:0] bt, input logic [DATA_W-1:0] bv);
      iss_valid = 1'b1; iss_op = op; iss_dst = dst;
      iss_a_pend = ap; iss_a_tag = at; iss_a_val = av;
      iss_b_pend = bp; iss_b_tag = bt; iss_b_val = bv;
      step();
      iss_valid = 1'b0;
   endtask

   task automatic t_reset();
      #1;
      chk("R9", "iss_ready", 32'(iss_ready), 32'd1);
      chk("R9", "disp_valid", 32'(disp_valid), 32'd0);
   endtask

   task automatic t_basic();
      fu_ready = 1'b0;
      issue(4'd3, 3'd5, 1'b0, 3'd0, 16'd10, 1'b0, 3'd0, 16'd20);
      #1 chk("R6", "no dispatch while unit busy", 32'(disp_valid), 32'd0);
      fu_ready = 1'b1;
      expect_disp("R3", 3'd5, 16'd10, 16'd20);
      chk("R2", "disp_op", 32'(disp_op), 32'd3);
      step();
      fu_ready = 1'b0;
      #1 chk("R7", "station freed", 32'(disp_valid), 32'd0);
   endtask

   task automatic t_cdb();
      issue(4'd1, 3'd1, 1'b1, 3'd2, 16'd0, 1'b0, 3'd0, 16'd7);
      fu_ready = 1'b1;
      #1 chk("R6", "operand missing", 32'(disp_valid), 32'd0);
      cdb_valid = 1'b1; cdb_tag = 3'd3; cdb_val = 16'd99;
      step();
      cdb_valid = 1'b0;
      #1 chk("R4", "other tag ignored", 32'(disp_valid), 32'd0);
      cdb_valid = 1'b1; cdb_tag = 3'd2; cdb_val = 16'd55;
      step();
      cdb_valid = 1'b0;
      expect_disp("R4", 3'd1, 16'd55, 16'd7);
      step();
      fu_ready = 1'b0;
   endtask

   task automatic t_forward();
      cdb_valid = 1'b1; cdb_tag = 3'd4; cdb_val = 16'd77;
      issue(4'd2, 3'd3, 1'b1, 3'd4, 16'd0, 1'b1, 3'd6, 16'd0);
      cdb_valid = 1'b0;
      fu_ready = 1'b1;
      #1 chk("R5", "B still pending", 32'(disp_valid), 32'd0);
      cdb_valid = 1'b1; cdb_tag = 3'd6; cdb_val = 16'd8;
      step();
      cdb_valid = 1'b0;
      expect_disp("R5", 3'd3, 16'd77, 16'd8);
      step();
      fu_ready = 1'b0;
   endtask

   task automatic t_order();
      issue(4'd1, 3'd1, 1'b1, 3'd5, 16'd0, 1'b0, 3'd0, 16'd1);
      issue(4'd1, 3'd2, 1'b0, 3'd0, 16'd2, 1'b0, 3'd0, 16'd2);
      issue(4'd1, 3'd3, 1'b0, 3'd0, 16'd3, 1'b0, 3'd0, 16'd3);
      fu_ready = 1'b1;
      expect_disp("R7", 3'd2, 16'd2, 16'd2);
      step();
      expect_disp("R10", 3'd3, 16'd3, 16'd3);
      cdb_valid = 1'b1; cdb_tag = 3'd5; cdb_val = 16'd33;
      step();
      cdb_valid = 1'b0;
      expect_disp("R7", 3'd1, 16'd33, 16'd1);
      step();
      #1 chk("R7", "pool drained", 32'(disp_valid), 32'd0);
      fu_ready = 1'b0;
   endtask

   task automatic t_full();
      for (int i = 0; i < N_STN; i++)
         issue(4'd5, 3'(4 + i), 1'b1, 3'd7, 16'd0, 1'b0, 3'd0, 16'(i));
      #1 chk("R1", "iss_ready when full", 32'(iss_ready), 32'd0);
      issue(4'd5, 3'd0, 1'b0, 3'd0, 16'hAA, 1'b0, 3'd0, 16'hBB);
      cdb_valid = 1'b1; cdb_tag = 3'd7; cdb_val = 16'd9;
      step();
      cdb_valid = 1'b0;
      fu_ready = 1'b1;
      for (int i = 0; i < N_STN; i++) begin
         expect_disp("R1", 3'(4 + i), 16'd9, 16'(i));
         step();
      end
      #1 chk("R1", "rejected issue absent", 32'(disp_valid), 32'd0);
      fu_ready = 1'b0;
   endtask

   task automatic t_rob();
      rob_free = 1'b0;
      issue(4'd6, 3'd6, 1'b0, 3'd0, 16'd1, 1'b0, 3'd0, 16'd1);
      rob_free = 1'b1;
      fu_ready = 1'b1;
      #1 chk("R1", "no rob slot", 32'(disp_valid), 32'd0);
      step();
      fu_ready = 1'b0;
   endtask

   task automatic t_flush();
      issue(4'd7, 3'd1, 1'b0, 3'd0, 16'd1, 1'b0, 3'd0, 16'd1);
      issue(4'd7, 3'd2, 1'b1, 3'd3, 16'd0, 1'b0, 3'd0, 16'd1);
      flush = 1'b1; fu_ready = 1'b1;
      iss_valid = 1'b1; iss_dst = 3'd4; iss_a_pend = 1'b0; iss_b_pend = 1'b0;
      #1 chk("R8", "no dispatch during flush", 32'(disp_valid), 32'd0);
      step();
      flush = 1'b0; iss_valid = 1'b0;
      #1 chk("R8", "empty after flush", 32'(disp_valid), 32'd0);
      chk("R8", "iss_ready after flush", 32'(iss_ready), 32'd1);
      cdb_valid = 1'b1; cdb_tag = 3'd3; cdb_val = 16'd5;
      step();
      cdb_valid = 1'b0;
      #1 chk("R8", "flushed waiter stays gone", 32'(disp_valid), 32'd0);
      fu_ready = 1'b0;
   endtask

   initial begin
      rst_n = 1'b0; flush = 1'b0; rob_free = 1'b1; iss_valid = 1'b0;
      iss_op = '0; iss_dst = '0; iss_a_pend = 1'b0; iss_a_tag = '0; iss_a_val = '0;
      iss_b_pend = 1'b0; iss_b_tag = '0; iss_b_val = '0;
      cdb_valid = 1'b0; cdb_tag = '0; cdb_val = '0; fu_ready = 1'b0;
      step(); step();
      rst_n = 1'b1;
      t_reset();
      t_basic();
      t_cdb();
      t_forward();
      t_order();
      t_full();
      t_rob();
      t_flush();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #40000;
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule